// File: doc/BRIEF.md
# Processor Failure Code Reporter

This block gathers failure indications from a processor's power-up checks and from its run-time error detection. The first failure seen after reset drives the active-low failure pin low and stops the core through a halt output. It then puts out a single bus read whose 32-bit address is itself the encoded failure report. The low byte of that address is a mask. Its bit 7 tells whether the remaining bits describe built-in self-test results (bit 7 = 1) or other failures (bit 7 = 0). The upper 24 bits are the fixed pattern 0xFEFFFF.

The read request uses a valid/ready handshake. `rd_valid_o` rises together with the failure pin and stays high, with its address unchanged, for as long as `rd_ready_i` is low. The transfer completes on the first clock edge where both are high. The block accepts no back-pressure in any other form and never withdraws a request. Once the read has been accepted, the block sits in a halted state. Only reset takes it out of that state. Until reset it ignores every further failure flag.

Top module: `fail_code_reporter`

## Requirements
- R1: From reset until a failure flag is sampled, `fail_n_o` is 1, `halt_o` is 0 and `rd_valid_o` is 0.
- R2: At the first clock edge that sees any failure input at 1, the outputs change right after that edge: `fail_n_o` goes to 0, `halt_o` goes to 1 and `rd_valid_o` goes to 1.
- R3: Every requested address has bits 31:8 equal to 0xFEFFFF and bits 1:0 equal to 0.
- R4: For a self-test report, address bit 7 is 1 and bits 6:2 copy `bist_err_i[4:0]`. The bit assignments are: bit 6 data RAM (`bist_err_i[4]`), bit 5 microcode ROM ([3]), bit 4 instruction cache ([2]), bit 3 data cache ([1]), bit 2 local-register cache or core ([0]).
- R5: For any other report, address bit 7 is 0 and bits 6:5 are 1. Bit 4 is `align_err_i`, bit 3 is `sys_err_i` and bit 2 is `bus_conf_fail_i`.
- R6: When any `bist_err_i` bit is set in the capturing cycle, the self-test form (R4) is issued, whatever the other flags are.
- R7: `rd_valid_o` stays high with `rd_addr_o` stable while `rd_ready_i` is low. After the handshake edge, `rd_valid_o` stays 0 until reset, so exactly one read carries the code.
- R8: After capture, `fail_n_o` stays 0 and `halt_o` stays 1 until reset. Failure flags that arrive later change neither the address nor the request count.
- R9: A reset returns the block to the R1 state. A failure after that reset is captured and reported afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_err_i | input | 5 | Self-test failure flags, one per unit |
| bus_conf_fail_i | input | 1 | Bus confidence test failed |
| align_err_i | input | 1 | Initialization data structure misaligned |
| sys_err_i | input | 1 | Run-time system error strobe |
| rd_ready_i | input | 1 | Bus accepts the read request |
| rd_valid_o | output | 1 | Read request pending |
| rd_addr_o | output | 32 | Read address carrying the fail code |
| fail_n_o | output | 1 | Failure pin, high while healthy |
| halt_o | output | 1 | Stops the core |

## Verification
Each self-test unit flag is driven alone, and each non-self-test flag is driven alone, so that every mask bit is tied to its own source. Mixed patterns set self-test flags and other flags together, which separates a correct priority from a merged or inverted mask. Random flag sets arrive after random idle time and meet random acknowledge delays, which tests how long the address holds under back-pressure. After each acknowledge, fresh flags are applied to show that no second read is issued and nothing is rewritten. Repeated resets between cases confirm that the block leaves its locked state only through reset.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned BIST_UNITS = 5;
  localparam int unsigned CODE_LOW_W = 8;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_REPORT = 2'd1,
    ST_HALTED = 2'd2
  } fcr_state_e;
endpackage

// File: rtl/fcr_code_enc.sv
module fcr_code_enc
  import fcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CODE_BASE = 32'hFEFF_FF00
) (
  input  logic [BIST_UNITS-1:0] bist_err,
  input  logic                  conf_fail,
  input  logic                  align_err,
  input  logic                  sys_err,
  output logic                  any_fail,
  output logic [ADDR_W-1:0]     code
);
  localparam int unsigned HI_W = ADDR_W - CODE_LOW_W;

  logic                  bist_hit;
  logic                  other_hit;
  logic [CODE_LOW_W-1:0] low_byte;

  assign bist_hit  = |bist_err;
  assign other_hit = conf_fail | align_err | sys_err;
  assign any_fail  = bist_hit | other_hit;

  // Self-test report wins over the other kinds when both are present.
  always_comb begin
    if (bist_hit) low_byte = {1'b1, bist_err, 2'b00};
    else          low_byte = {3'b011, align_err, sys_err, conf_fail, 2'b00};
  end

  assign code = {CODE_BASE[ADDR_W-1 -: HI_W], low_byte};
endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl
  import fcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_fail,
  input  logic [ADDR_W-1:0] code,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fail_n,
  output logic              halt
);
  fcr_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      rd_addr <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (any_fail) begin
          state_q <= ST_REPORT;
          rd_addr <= code;
        end
        ST_REPORT: if (rd_ready) state_q <= ST_HALTED;
        ST_HALTED: state_q <= ST_HALTED;
        default:   state_q <= ST_HALTED;
      endcase
    end
  end

  assign rd_valid = (state_q == ST_REPORT);
  assign halt     = (state_q != ST_RUN);
  assign fail_n   = (state_q == ST_RUN);

  AST_CAPTURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && any_fail) |=> (rd_valid && !fail_n && rd_addr == $past(code))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R7
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && !fail_n && $stable(rd_addr))); // R8
endmodule

// File: rtl/fail_code_reporter.sv
module fail_code_reporter
  import fcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bist_err_i,
  input  logic        bus_conf_fail_i,
  input  logic        align_err_i,
  input  logic        sys_err_i,
  input  logic        rd_ready_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_addr_o,
  output logic        fail_n_o,
  output logic        halt_o
);
  localparam int unsigned ADDR_W = 32;

  logic              any_fail;
  logic [ADDR_W-1:0] code;

  fcr_code_enc #(.ADDR_W(ADDR_W), .CODE_BASE(32'hFEFF_FF00)) u_enc (
    .bist_err  (bist_err_i),
    .conf_fail (bus_conf_fail_i),
    .align_err (align_err_i),
    .sys_err   (sys_err_i),
    .any_fail  (any_fail),
    .code      (code)
  );

  fcr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_fail (any_fail),
    .code     (code),
    .rd_ready (rd_ready_i),
    .rd_valid (rd_valid_o),
    .rd_addr  (rd_addr_o),
    .fail_n   (fail_n_o),
    .halt     (halt_o)
  );

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_addr_o[31:8] == 24'hFEFFFF && rd_addr_o[1:0] == 2'b00)); // R3
  AST_OTHER_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_addr_o[7]) |-> (rd_addr_o[6:5] == 2'b11)); // R5
  AST_BIST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_o && |bist_err_i) |=> rd_addr_o[7]); // R6
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_o |-> (fail_n_o && !rd_valid_o)); // R1
endmodule

// File: tb/fail_code_reporter_tb.sv
module fail_code_reporter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bist_err_i = '0;
  logic        bus_conf_fail_i = 1'b0;
  logic        align_err_i = 1'b0;
  logic        sys_err_i = 1'b0;
  logic        rd_ready_i = 1'b0;
  logic        rd_valid_o;
  logic [31:0] rd_addr_o;
  logic        fail_n_o;
  logic        halt_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fail_code_reporter u_dut (
    .clk(clk), .rst_n(rst_n), .bist_err_i(bist_err_i),
    .bus_conf_fail_i(bus_conf_fail_i), .align_err_i(align_err_i),
    .sys_err_i(sys_err_i), .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o),
    .rd_addr_o(rd_addr_o), .fail_n_o(fail_n_o), .halt_o(halt_o)
  );

  function automatic logic [31:0] exp_code(logic [4:0] b, logic c, logic a, logic s);
    if (b != 5'd0) return {24'hFEFFFF, 1'b1, b, 2'b00};
    return {24'hFEFFFF, 3'b011, a, s, c, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    bist_err_i = '0; bus_conf_fail_i = 0; align_err_i = 0; sys_err_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; clear_flags(); rd_ready_i = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fail_n idle", 32'(fail_n_o), 32'd1);
    chk("R1 halt idle", 32'(halt_o), 32'd0);
    chk("R1 rd_valid idle", 32'(rd_valid_o), 32'd0);
  endtask

  // Apply one failure pattern for one cycle, then handle the read.
  task automatic run_case(logic [4:0] b, logic c, logic a, logic s,
                          int idle, int delay, string tag);
    logic [31:0] e;
    e = exp_code(b, c, a, s);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      chk("R1 still idle", 32'(fail_n_o), 32'd1);
    end
    bist_err_i = b; bus_conf_fail_i = c; align_err_i = a; sys_err_i = s;
    @(negedge clk);
    clear_flags();
    chk({"R2 fail_n low ", tag}, 32'(fail_n_o), 32'd0);
    chk({"R2 halt high ", tag}, 32'(halt_o), 32'd1);
    chk({"R2 rd_valid ", tag}, 32'(rd_valid_o), 32'd1);
    chk({"R3 R4 R5 R6 code ", tag}, rd_addr_o, e);
    for (int i = 0; i < delay; i++) begin
      bist_err_i = 5'($urandom); sys_err_i = 1'($urandom);
      @(negedge clk);
      chk("R7 hold valid", 32'(rd_valid_o), 32'd1);
      chk("R7 hold addr", rd_addr_o, e);
    end
    clear_flags();
    rd_ready_i = 1;
    @(negedge clk);
    rd_ready_i = 0;
    chk("R7 one read", 32'(rd_valid_o), 32'd0);
    for (int i = 0; i < 3; i++) begin
      bist_err_i = 5'($urandom); bus_conf_fail_i = 1'($urandom);
      align_err_i = 1'($urandom); sys_err_i = 1;
      rd_ready_i = 1'($urandom);
      @(negedge clk);
      chk("R8 no new read", 32'(rd_valid_o), 32'd0);
      chk("R8 fail_n held", 32'(fail_n_o), 32'd0);
      chk("R8 halt held", 32'(halt_o), 32'd1);
      chk("R8 addr kept", rd_addr_o, e);
    end
    clear_flags(); rd_ready_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // Directed: each self-test unit alone.
    for (int k = 0; k < 5; k++) begin
      run_case(5'(1 << k), 0, 0, 0, 1, 1, "R4 unit");
      do_reset();  // R9
    end
    run_case(5'd0, 1, 0, 0, 0, 0, "R5 conf");   do_reset();
    run_case(5'd0, 0, 1, 0, 2, 3, "R5 align");  do_reset();
    run_case(5'd0, 0, 0, 1, 0, 2, "R5 syserr"); do_reset();
    run_case(5'b10001, 1, 1, 1, 0, 1, "R6 prio"); do_reset();
    // Random mix.
    for (int t = 0; t < 40; t++) begin
      logic [4:0] b;
      logic c, a, s;
      b = ($urandom % 2 == 0) ? 5'($urandom) : 5'd0;
      c = 1'($urandom); a = 1'($urandom); s = 1'($urandom);
      if (b == 0 && !c && !a && !s) s = 1;
      run_case(b, c, a, s, int'($urandom % 5), int'($urandom % 6), "rand");
      do_reset();  // R9
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      done = 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule